// File: doc/BRIEF.md
# Protection Region Register Bank

This block holds the software-visible configuration of an eight-region memory protection unit. A simple word-wide bus reaches five registers: a read-only identification word, a global control word, a region selector, and two window registers. The two window registers show the base address and the attribute word of the region the selector currently points at. Each region keeps its own stored base and attributes. The attribute word carries the region's size, its subregion disable mask, its permission code, its execute-never flag and its enable bit.

All stored region fields and the three global control bits leave the block as flat output vectors. A separate access checker consumes them. A region's exported enable is set only when its stored enable bit is set and its size code describes at least 32 bytes. Software can program a region in two writes. The first is a base write that names the region in its low bits and sets the "take the region number from here" flag. The second is an attribute write to the same region.

The bus register offsets are word indices. Index 0 is identification, 1 is control, 2 is the selector, 3 is the base window and 4 is the attribute window. Indices 5 to 7 are unmapped: they read zero and ignore writes. Read data is registered.

Top module: `prot_regbank`

## Requirements
- R1: After reset, the control bits are 0, the selector reads 0, and every region's stored base and attributes are 0, so no exported region enable is set.
- R2: Index 0 always reads 32'h0000_0800: the region count in bits 15:8, with zero in bits 23:16 and in bit 0. Writes to index 0 change nothing.
- R3: Index 1 stores write bits 2:0 and drives them out. Bit 0 is unit enable, bit 1 is active-in-fault-handlers and bit 2 is privileged default-map fallback. Bits 31:3 read zero.
- R4: Index 2 takes write bits 7:0 as the selected region when that value is below the region count. A value of the region count or more is ignored and the old selection stays.
- R5: A write to index 3 with bit 4 clear stores bits 31:5 as the base of the selected region. Reads of index 3 return the selected region's base in bits 31:5, 0 in bit 4 and the selector's low four bits in bits 3:0.
- R6: A write to index 3 with bit 4 set and bits 3:0 below the region count stores the selector and that region's base from the same write. With bit 4 set and bits 3:0 out of range, the whole write is ignored.
- R7: A write to index 4 stores into the selected region the following fields: execute-never from bit 28, permission from bits 26:24, subregion disable mask from bits 15:8, size code from bits 5:1 and enable from bit 0. A read returns those fields in the same places, with zero in all other bits.
- R8: A region's exported enable is its stored enable bit AND (size code >= 4). A size code below 4 is still stored and read back as written.
- R9: Read data appears on `bus_rdata` one clock after the cycle holding the read request. It holds its value in every cycle without a read.
- R10: A window write changes only the targeted region; all other regions' exported fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (3) | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ctl_enable | output | 1 | Control bit 0: unit enabled |
| ctl_fault_active | output | 1 | Control bit 1: active in fault handlers |
| ctl_priv_default | output | 1 | Control bit 2: privileged default-map fallback |
| rg_base_o | output | NUM_REGIONS*27 (216) | Region base bits 31:5, region g at [g*27 +: 27] |
| rg_size_o | output | NUM_REGIONS*5 (40) | Size codes |
| rg_srd_o | output | NUM_REGIONS*8 (64) | Subregion disable masks |
| rg_perm_o | output | NUM_REGIONS*3 (24) | Permission codes |
| rg_xn_o | output | NUM_REGIONS (8) | Execute-never flags |
| rg_en_o | output | NUM_REGIONS (8) | Effective region enables |

## Verification
The directed patterns cover several cases. Plain selector writes are compared with out-of-range selector values, which tells whether a bounds check exists. Base writes with the flag clear are compared with flag-set writes, which tells the two selection paths apart and shows whether the selector moves. An all-ones attribute write exposes reserved-bit masking. Size codes 3 and 4 bracket the enable threshold. A long run of random bus traffic follows, including unmapped indices and out-of-range region numbers. Every output is compared each clock against a behavioural model, which shows whether writes leak into regions that were not targeted.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int BASE_W         = 27;
  localparam int MIN_SIZE_CODE  = 4;
  localparam int RA_TYPE        = 0;
  localparam int RA_CTRL        = 1;
  localparam int RA_RNUM        = 2;
  localparam int RA_BASE        = 3;
  localparam int RA_ATTR        = 4;

  typedef struct packed {
    logic       xn;
    logic [2:0] perm;
    logic [7:0] srd;
    logic [4:0] size;
    logic       en;
  } attr_t;

  function automatic attr_t attr_unpack(input logic [31:0] w);
    attr_t a;
    a.xn   = w[28];
    a.perm = w[26:24];
    a.srd  = w[15:8];
    a.size = w[5:1];
    a.en   = w[0];
    return a;
  endfunction

  function automatic logic [31:0] attr_pack(input attr_t a);
    logic [31:0] w;
    w        = '0;
    w[28]    = a.xn;
    w[26:24] = a.perm;
    w[15:8]  = a.srd;
    w[5:1]   = a.size;
    w[0]     = a.en;
    return w;
  endfunction
endpackage

// File: rtl/prot_ctrl_regs.sv
module prot_ctrl_regs #(
  parameter int NUM_REGIONS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_ctrl,
  input  logic        wr_rnum,
  input  logic        wr_base_pick,
  input  logic [31:0] wdata,
  output logic [2:0]  ctrl_q,
  output logic [7:0]  rnum_q
);
  localparam logic [7:0] NR8 = 8'(NUM_REGIONS);

  logic rnum_ok, pick_ok;
  assign rnum_ok = wdata[7:0] < NR8;
  assign pick_ok = {4'b0, wdata[3:0]} < NR8;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      rnum_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata[2:0];
      if (wr_rnum && rnum_ok) rnum_q <= wdata[7:0];
      else if (wr_base_pick && pick_ok) rnum_q <= {4'b0, wdata[3:0]};
    end
  end
endmodule

// File: rtl/prot_region_store.sv
module prot_region_store
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int IDX_W       = 3
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                base_we,
  input  logic [IDX_W-1:0]                    base_idx,
  input  logic [BASE_W-1:0]                   base_val,
  input  logic                                attr_we,
  input  logic [IDX_W-1:0]                    attr_idx,
  input  attr_t                               attr_val,
  output logic [NUM_REGIONS-1:0][BASE_W-1:0]  base_q,
  output attr_t [NUM_REGIONS-1:0]             attr_q
);
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_rgn
    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g] <= '0;
        attr_q[g] <= '0;
      end else begin
        if (base_we && base_idx == IDX_W'(g)) base_q[g] <= base_val;
        if (attr_we && attr_idx == IDX_W'(g)) attr_q[g] <= attr_val;
      end
    end
  end
endmodule

// File: rtl/prot_rd_mux.sv
module prot_rd_mux
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        ctrl,
  input  logic [7:0]        rnum,
  input  logic [BASE_W-1:0] base_sel,
  input  attr_t             attr_sel,
  output logic [31:0]       rd_next
);
  localparam logic [7:0] NR8 = 8'(NUM_REGIONS);

  always_comb begin
    rd_next = '0;
    case (addr)
      ADDR_W'(RA_TYPE): rd_next = {16'h0, NR8, 8'h0};
      ADDR_W'(RA_CTRL): rd_next = {29'h0, ctrl};
      ADDR_W'(RA_RNUM): rd_next = {24'h0, rnum};
      ADDR_W'(RA_BASE): rd_next = {base_sel, 1'b0, rnum[3:0]};
      ADDR_W'(RA_ATTR): rd_next = attr_pack(attr_sel);
      default:          rd_next = '0;
    endcase
  end
endmodule

// File: rtl/prot_regbank.sv
module prot_regbank
  import prot_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_sel,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          ctl_enable,
  output logic                          ctl_fault_active,
  output logic                          ctl_priv_default,
  output logic [NUM_REGIONS*27-1:0]     rg_base_o,
  output logic [NUM_REGIONS*5-1:0]      rg_size_o,
  output logic [NUM_REGIONS*8-1:0]      rg_srd_o,
  output logic [NUM_REGIONS*3-1:0]      rg_perm_o,
  output logic [NUM_REGIONS-1:0]        rg_xn_o,
  output logic [NUM_REGIONS-1:0]        rg_en_o
);
  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam logic [7:0] NR8 = 8'(NUM_REGIONS);

  logic wr_hit, wr_ctrl, wr_rnum, wr_base, wr_attr, pick_ok;
  logic [2:0] ctrl_q;
  logic [7:0] cur_rnum;
  logic [IDX_W-1:0] cur_idx, base_idx;
  logic base_we;
  logic [NUM_REGIONS-1:0][BASE_W-1:0] base_q;
  attr_t [NUM_REGIONS-1:0] attr_q;
  logic [31:0] rd_next;

  assign wr_hit  = bus_sel && bus_wr;
  assign wr_ctrl = wr_hit && bus_addr == ADDR_W'(RA_CTRL);
  assign wr_rnum = wr_hit && bus_addr == ADDR_W'(RA_RNUM);
  assign wr_base = wr_hit && bus_addr == ADDR_W'(RA_BASE);
  assign wr_attr = wr_hit && bus_addr == ADDR_W'(RA_ATTR);
  assign pick_ok = {4'b0, bus_wdata[3:0]} < NR8;

  assign cur_idx  = cur_rnum[IDX_W-1:0];
  assign base_we  = wr_base && (!bus_wdata[4] || pick_ok);
  assign base_idx = bus_wdata[4] ? bus_wdata[IDX_W-1:0] : cur_idx;

  prot_ctrl_regs #(.NUM_REGIONS(NUM_REGIONS)) ctrl_i (
    .clk(clk), .rst(rst),
    .wr_ctrl(wr_ctrl), .wr_rnum(wr_rnum),
    .wr_base_pick(wr_base && bus_wdata[4]),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .rnum_q(cur_rnum)
  );

  prot_region_store #(.NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)) store_i (
    .clk(clk), .rst(rst),
    .base_we(base_we), .base_idx(base_idx), .base_val(bus_wdata[31:5]),
    .attr_we(wr_attr), .attr_idx(cur_idx), .attr_val(attr_unpack(bus_wdata)),
    .base_q(base_q), .attr_q(attr_q)
  );

  prot_rd_mux #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) mux_i (
    .addr(bus_addr), .ctrl(ctrl_q), .rnum(cur_rnum),
    .base_sel(base_q[cur_idx]), .attr_sel(attr_q[cur_idx]), .rd_next(rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_next;
  end

  assign ctl_enable       = ctrl_q[0];
  assign ctl_fault_active = ctrl_q[1];
  assign ctl_priv_default = ctrl_q[2];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_out
    assign rg_base_o[g*BASE_W +: BASE_W] = base_q[g];
    assign rg_size_o[g*5 +: 5]           = attr_q[g].size;
    assign rg_srd_o[g*8 +: 8]            = attr_q[g].srd;
    assign rg_perm_o[g*3 +: 3]           = attr_q[g].perm;
    assign rg_xn_o[g]                    = attr_q[g].xn;
    assign rg_en_o[g] = attr_q[g].en && (attr_q[g].size >= 5'(MIN_SIZE_CODE));
  end
endmodule

// File: rtl/prot_regbank_chk.sv
module prot_regbank_chk #(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_sel,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [31:0]               bus_rdata,
  input logic                      ctl_enable,
  input logic                      ctl_fault_active,
  input logic                      ctl_priv_default,
  input logic [NUM_REGIONS*27-1:0] rg_base_o,
  input logic [NUM_REGIONS*5-1:0]  rg_size_o,
  input logic [NUM_REGIONS*8-1:0]  rg_srd_o,
  input logic [NUM_REGIONS-1:0]    rg_en_o,
  input logic [7:0]                cur_rnum
);
  localparam logic [7:0] NR8 = 8'(NUM_REGIONS);

  assert_type_read_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_addr == ADDR_W'(0)) |=> bus_rdata == {16'h0, NR8, 8'h0});

  assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr && bus_addr == ADDR_W'(1)) |=>
      $stable({ctl_enable, ctl_fault_active, ctl_priv_default}));

  assert_sel_range_R4: assert property (@(posedge clk) disable iff (rst)
    cur_rnum < NR8);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

  assert_regions_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && bus_wr) |=> ($stable(rg_base_o) && $stable(rg_size_o) && $stable(rg_srd_o)));

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_en
    assert_en_size_R8: assert property (@(posedge clk) disable iff (rst)
      rg_en_o[g] |-> rg_size_o[g*5 +: 5] >= 5'd4);
  end
endmodule

bind prot_regbank prot_regbank_chk #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .ctl_enable(ctl_enable), .ctl_fault_active(ctl_fault_active),
  .ctl_priv_default(ctl_priv_default), .rg_base_o(rg_base_o), .rg_size_o(rg_size_o),
  .rg_srd_o(rg_srd_o), .rg_en_o(rg_en_o), .cur_rnum(cur_rnum)
);

// File: tb/prot_regbank_tb_top.sv
`timescale 1ns/1ps
module prot_regbank_tb_top;
  localparam int NR = 8;

  logic clk = 0;
  logic rst = 1;
  logic bus_sel = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ctl_enable, ctl_fault_active, ctl_priv_default;
  logic [NR*27-1:0] rg_base_o;
  logic [NR*5-1:0] rg_size_o;
  logic [NR*8-1:0] rg_srd_o;
  logic [NR*3-1:0] rg_perm_o;
  logic [NR-1:0] rg_xn_o, rg_en_o;

  always #2 clk = ~clk;

  prot_regbank dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctl_enable(ctl_enable),
    .ctl_fault_active(ctl_fault_active), .ctl_priv_default(ctl_priv_default),
    .rg_base_o(rg_base_o), .rg_size_o(rg_size_o), .rg_srd_o(rg_srd_o),
    .rg_perm_o(rg_perm_o), .rg_xn_o(rg_xn_o), .rg_en_o(rg_en_o)
  );

  int checks = 0, fails = 0;
  bit done = 0, cmp_on = 0;

  // behavioural reference
  int unsigned m_ctrl, m_rnum, m_rdata;
  int unsigned m_base[NR];
  int unsigned m_attr[NR];
  localparam int unsigned ATTR_MASK = 32'h1700_FF3F;

  always @(posedge clk) begin
    if (rst) begin
      m_ctrl = 0; m_rnum = 0; m_rdata = 0;
      foreach (m_base[i]) begin m_base[i] = 0; m_attr[i] = 0; end
    end else if (bus_sel) begin
      if (bus_wr) begin
        case (bus_addr)
          3'd1: m_ctrl = bus_wdata & 7;
          3'd2: if ((bus_wdata & 255) < NR) m_rnum = bus_wdata & 255;
          3'd3: begin
            if (bus_wdata[4]) begin
              if ((bus_wdata & 15) < NR) begin
                m_rnum = bus_wdata & 15;
                m_base[m_rnum] = bus_wdata >> 5;
              end
            end else m_base[m_rnum] = bus_wdata >> 5;
          end
          3'd4: m_attr[m_rnum] = bus_wdata & ATTR_MASK;
          default: ;
        endcase
      end else begin
        case (bus_addr)
          3'd0: m_rdata = NR << 8;
          3'd1: m_rdata = m_ctrl;
          3'd2: m_rdata = m_rnum;
          3'd3: m_rdata = (m_base[m_rnum] << 5) | (m_rnum & 15);
          3'd4: m_rdata = m_attr[m_rnum];
          default: m_rdata = 0;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) if (cmp_on && !done) begin
    chk("R9 rdata", bus_rdata, m_rdata);
    chk("R3 ctrl", {29'h0, ctl_priv_default, ctl_fault_active, ctl_enable}, m_ctrl);
    for (int i = 0; i < NR; i++) begin
      int unsigned a;
      a = m_attr[i];
      chk($sformatf("R10 base rgn%0d", i), 32'(rg_base_o[i*27 +: 27]), m_base[i]);
      chk($sformatf("R7 attr rgn%0d", i),
          {3'h0, rg_xn_o[i], 1'b0, rg_perm_o[i*3 +: 3], 8'h0, rg_srd_o[i*8 +: 8], 2'b0, rg_size_o[i*5 +: 5], 1'b0},
          a & 32'h1700_FF3E);
      chk($sformatf("R8 en rgn%0d", i), 32'(rg_en_o[i]),
          32'((a & 1) != 0 && ((a >> 1) & 31) >= 4));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    cmp_on = 1;
    @(negedge clk);
    chk("R1 en after reset", 32'(rg_en_o), 0);
    chk("R1 ctrl after reset", {29'h0, ctl_priv_default, ctl_fault_active, ctl_enable}, 0);
    rd(3'd2, v); chk("R1 selector", v, 0);
    rd(3'd4, v); chk("R1 attr", v, 0);
    rd(3'd0, v); chk("R2 type", v, 32'h0000_0800);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, v); chk("R2 type after write", v, 32'h0000_0800);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); chk("R3 ctrl read", v, 7);
    chk("R3 ctrl pins", {29'h0, ctl_priv_default, ctl_fault_active, ctl_enable}, 7);
    wr(3'd2, 32'h0000_0105);
    rd(3'd2, v); chk("R4 select 5", v, 5);
    wr(3'd2, 32'h0000_0008);
    rd(3'd2, v); chk("R4 out-of-range ignored", v, 5);
    wr(3'd3, 32'h2000_0047);
    rd(3'd3, v); chk("R5 base read", v, 32'h2000_0045);
    chk("R5 base pins", 32'(rg_base_o[5*27 +: 27]), 32'h2000_0040 >> 5);
    wr(3'd3, 32'h1000_0013);
    rd(3'd2, v); chk("R6 selector moved", v, 3);
    rd(3'd3, v); chk("R6 base read", v, 32'h1000_0003);
    chk("R10 other region kept", 32'(rg_base_o[5*27 +: 27]), 32'h2000_0040 >> 5);
    wr(3'd3, 32'h4000_001C);
    rd(3'd2, v); chk("R6 bad index ignored", v, 3);
    rd(3'd3, v); chk("R6 bad index base kept", v, 32'h1000_0003);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, v); chk("R7 attr mask", v, 32'h1700_FF3F);
    chk("R7 enable pin", 32'(rg_en_o[3]), 1);
    wr(3'd4, 32'h0000_0007);
    rd(3'd4, v); chk("R8 size 3 stored", v, 7);
    chk("R8 size 3 disables", 32'(rg_en_o[3]), 0);
    wr(3'd4, 32'h0000_0009);
    chk("R8 size 4 enables", 32'(rg_en_o[3]), 1);
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R9 unmapped reads zero", v, 0);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      bus_sel = ($urandom % 4) != 0;
      bus_wr  = $urandom % 2;
      bus_addr = 3'($urandom % 8);
      bus_wdata = $urandom;
      if (bus_addr == 3'd2) bus_wdata = $urandom % 12;
    end
    @(negedge clk);
    bus_sel = 0;
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule